// File: doc/BRIEF.md
# Dual-Preset Selectable Integer Clock Divider

This block derives a slower clock from a reference clock by whole-number division. Two ratio values are held ready on its inputs, and a single select line decides which one is in force. This lets a board-level control pin move an output between two frequencies without reprogramming anything. A second, cascaded divider stage multiplies the output period by a further whole number. The whole output is held low until the surrounding logic signals that initialization is complete.

The block runs entirely in the reference clock domain and produces a registered output. Its edges fall only on reference clock edges. Changes to the select line, the preset values or the post-divider setting are collected and applied together at the end of the complete output period. The running waveform is therefore never cut short.

Top module: `clkdiv_dual_preset`

## Requirements
- R1: With `sel_b` = 0 the first-stage ratio N comes from `ratio_a`; with `sel_b` = 1 it comes from `ratio_b`.
- R2: The effective first-stage ratio N lies between 8 and 255. A preset value below 8 (including 0) is used as 8.
- R3: The post-divider ratio M (1 to 63, from `post_div`) sets the output period to N*M reference cycles. For M > 1 the output is high for floor(M/2)*N cycles and low for the rest of the period.
- R4: A `post_div` value of 0 divides by 1. After reset, the held ratios are N = 8 and M = 1.
- R5: If `init_done` was low at the most recent reference edge, `clk_out` is low. At the first edge where `init_done` is sampled high, a new period starts, and `clk_out` goes high after that edge.
- R6: Ratios are captured at the start edge and then only at the edge that ends a full output period of N*M cycles. Input changes made inside a period have no effect on that period's length or high time.
- R7: With M = 1 the output is high for floor(N/2) reference cycles and then low for the remaining N - floor(N/2) cycles. Each period begins with the high phase.
- R8: Active-low `rst_n` acts asynchronously. It clears both counters and drives `clk_out` low. After release, `clk_out` stays low until `init_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_a | input | 8 | Preset ratio used when `sel_b` = 0 |
| ratio_b | input | 8 | Preset ratio used when `sel_b` = 1 |
| sel_b | input | 1 | Preset select (0 = A, 1 = B) |
| post_div | input | 6 | Post-divider ratio, 0 treated as 1 |
| init_done | input | 1 | Initialization complete; output squelched while low |
| clk_out | output | 1 | Divided clock output |

## Verification
Two events can collide in one cycle: a toggle of the select line (or a new preset or post-divider value) and the edge that closes an output period. Random select toggles on roughly one cycle in four, over small ratios, make this collision frequent. The init_done rise or fall landing on a period boundary is provoked the same way. In every cycle the output is compared with a bench model that keeps only a position within the period, the period length N*M and the high time. That model reloads both lengths solely at a boundary, so a value taken one cycle early or late shows up as a shifted edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // default geometry of the divider
  localparam int unsigned DEF_NW   = 8;  // first-stage ratio width
  localparam int unsigned DEF_MW   = 6;  // post-divider ratio width
  localparam int unsigned DEF_NMIN = 8;  // smallest first-stage ratio
endpackage

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel #(
  parameter int unsigned NW   = clkdiv_pkg::DEF_NW,
  parameter int unsigned MW   = clkdiv_pkg::DEF_MW,
  parameter int unsigned NMIN = clkdiv_pkg::DEF_NMIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sel_b,
  input  logic [NW-1:0] ratio_a,
  input  logic [NW-1:0] ratio_b,
  input  logic [MW-1:0] post_div,
  output logic [NW-1:0] nxt_n,
  output logic [MW-1:0] nxt_m,
  output logic [NW-1:0] cur_n,
  output logic [MW-1:0] cur_m
);
  localparam logic [NW-1:0] N_FLOOR = NW'(NMIN);

  function automatic logic [NW-1:0] clamp_ratio(input logic [NW-1:0] r);
    return (r < N_FLOOR) ? N_FLOOR : r;
  endfunction

  function automatic logic [MW-1:0] clamp_post(input logic [MW-1:0] p);
    return (p == '0) ? MW'(1) : p;
  endfunction

  logic [NW-1:0] picked;
  assign picked = sel_b ? ratio_b : ratio_a;  // R1
  assign nxt_n  = load ? clamp_ratio(picked)   : cur_n;
  assign nxt_m  = load ? clamp_post(post_div)  : cur_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= N_FLOOR;
      cur_m <= MW'(1);
    end else begin
      cur_n <= nxt_n;
      cur_m <= nxt_m;
    end
  end

  assert_ratio_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_n >= N_FLOOR);
  assert_post_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_m != '0);
  assert_hold_midperiod_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cur_n) && $stable(cur_m)));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned NW = clkdiv_pkg::DEF_NW,
  parameter int unsigned MW = clkdiv_pkg::DEF_MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [NW-1:0] cur_n,
  input  logic [MW-1:0] cur_m,
  output logic [NW-1:0] nxt_cnt,
  output logic [MW-1:0] nxt_k,
  output logic          end_all,
  output logic [NW-1:0] cnt,
  output logic [MW-1:0] k
);
  logic end_s1;
  assign end_s1  = (cnt == cur_n - NW'(1));
  assign end_all = end_s1 && (k == cur_m - MW'(1));

  always_comb begin
    if (clear) begin
      nxt_cnt = '0;
      nxt_k   = '0;
    end else if (end_s1) begin
      nxt_cnt = '0;
      nxt_k   = end_all ? '0 : k + MW'(1);
    end else begin
      nxt_cnt = cnt + NW'(1);
      nxt_k   = k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      k   <= '0;
    end else begin
      cnt <= nxt_cnt;
      k   <= nxt_k;
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_n);
  assert_post_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    k < cur_m);
endmodule

// File: rtl/clkdiv_dual_preset.sv
module clkdiv_dual_preset #(
  parameter int unsigned NW   = clkdiv_pkg::DEF_NW,
  parameter int unsigned MW   = clkdiv_pkg::DEF_MW,
  parameter int unsigned NMIN = clkdiv_pkg::DEF_NMIN
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [NW-1:0] ratio_a,
  input  logic [NW-1:0] ratio_b,
  input  logic          sel_b,
  input  logic [MW-1:0] post_div,
  input  logic          init_done,
  output logic          clk_out
);
  // high phase of a position (c within first stage, q within post stage)
  function automatic logic phase_high(input logic [NW-1:0] c, input logic [MW-1:0] q,
                                      input logic [NW-1:0] n, input logic [MW-1:0] m);
    if (m == MW'(1)) return c < (n >> 1);  // R7
    return q < (m >> 1);                   // R3
  endfunction

  logic          run_q;
  logic          out_q;
  logic          clear;
  logic          load;
  logic          end_all;
  logic [NW-1:0] nxt_n, cur_n, nxt_cnt, cnt;
  logic [MW-1:0] nxt_m, cur_m, nxt_k, k;

  assign clear = !init_done || !run_q;
  assign load  = clear || end_all;        // R6

  clkdiv_ratio_sel #(.NW(NW), .MW(MW), .NMIN(NMIN)) u_sel (
    .clk(clk_ref), .rst_n(rst_n), .load(load), .sel_b(sel_b),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .post_div(post_div),
    .nxt_n(nxt_n), .nxt_m(nxt_m), .cur_n(cur_n), .cur_m(cur_m)
  );

  clkdiv_counter #(.NW(NW), .MW(MW)) u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .clear(clear), .cur_n(cur_n), .cur_m(cur_m),
    .nxt_cnt(nxt_cnt), .nxt_k(nxt_k), .end_all(end_all), .cnt(cnt), .k(k)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      run_q <= init_done;
      out_q <= init_done && phase_high(nxt_cnt, nxt_k, nxt_n, nxt_m);  // R5
    end
  end

  assign clk_out = out_q;

  assert_squelch_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !init_done |=> !clk_out);
  assert_period_starts_high_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_q && cnt == '0 && k == '0) |-> clk_out);
  assert_low_phase_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_q && cur_m == MW'(1) && cnt == (cur_n >> 1)) |-> !clk_out);
endmodule

// File: tb/clkdiv_dual_preset_bench.sv
module clkdiv_dual_preset_bench;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ratio_a = 8'd8;
  logic [7:0] ratio_b = 8'd8;
  logic       sel_b = 1'b0;
  logic [5:0] post_div = 6'd1;
  logic       init_done = 1'b0;
  logic       clk_out;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string tag = "R8 reset";

  int m_pos = 0, m_per = 8, m_high = 4;
  bit m_run = 0, exp_out = 0;

  always #2.5 clk_ref = ~clk_ref;

  clkdiv_dual_preset u_clkdiv_dual_preset (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .sel_b(sel_b), .post_div(post_div), .init_done(init_done), .clk_out(clk_out)
  );

  function automatic int eff_ratio(int r);
    return (r < 8) ? 8 : r;
  endfunction

  function automatic int eff_post(int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic load_model();
    int n = eff_ratio(sel_b ? int'(ratio_b) : int'(ratio_a));
    int m = eff_post(int'(post_div));
    m_per  = n * m;
    m_high = (m == 1) ? n / 2 : (m / 2) * n;
  endtask

  // effect of the coming rising edge on the expected output
  task automatic step_model();
    if (!rst_n) begin
      m_run = 0; m_pos = 0; exp_out = 0;
    end else if (!init_done) begin
      m_run = 0; m_pos = 0; load_model(); exp_out = 0;
    end else begin
      if (!m_run) begin
        m_run = 1; m_pos = 0; load_model();
      end else if (m_pos == m_per - 1) begin
        m_pos = 0; load_model();
      end else begin
        m_pos++;
      end
      exp_out = (m_pos < m_high);
    end
  endtask

  task automatic tick();
    step_model();
    @(negedge clk_ref);
    checks++;
    if (clk_out !== exp_out) begin
      fails++;
      $display("FAIL %s: clk_out=%0b expected %0b at %0t", tag, clk_out, exp_out, $time);
    end
  endtask

  task automatic run(int cycles, int toggle_pct);
    for (int i = 0; i < cycles; i++) begin
      if (toggle_pct > 0 && $urandom_range(99) < toggle_pct) sel_b = ~sel_b;
      tick();
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    tag = "R8 reset state";
    run(6, 0);
    rst_n = 1'b1;
    tag = "R5 squelch before init";
    for (int i = 0; i < 40; i++) begin
      ratio_a = 8'($urandom_range(255, 8)); sel_b = ~sel_b;
      tick();
    end
    sel_b = 0; ratio_a = 8'd8; post_div = 6'd1;
    tag = "R7 N=8 even duty";
    init_done = 1'b1;
    run(64, 0);
    tag = "R7 N=255 odd duty";
    ratio_a = 8'd255;
    run(700, 0);
    tag = "R3 N=9 M=3";
    ratio_a = 8'd9; post_div = 6'd3;
    run(200, 0);
    tag = "R1 preset A/B select";
    ratio_a = 8'd10; ratio_b = 8'd14; post_div = 6'd1;
    for (int j = 0; j < 8; j++) begin
      sel_b = ~sel_b;
      run(53, 0);
    end
    tag = "R2 ratio below floor";
    sel_b = 0; ratio_a = 8'd5;
    run(100, 0);
    ratio_a = 8'd0;
    run(60, 0);
    tag = "R4 post zero is divide-by-1";
    ratio_a = 8'd12; post_div = 6'd0;
    run(100, 0);
    tag = "R3 post 63 with N=8";
    sel_b = 1; ratio_b = 8'd8; post_div = 6'd63;
    run(1100, 0);
    tag = "R6 select at period boundary";
    for (int s = 0; s < 6; s++) begin
      ratio_a = 8'($urandom_range(40, 8)); ratio_b = 8'($urandom_range(40, 8));
      post_div = 6'($urandom_range(3));
      run(500, 25);
    end
    tag = "R5 init drop mid-run";
    init_done = 1'b0;
    run(30, 20);
    init_done = 1'b1;
    run(200, 10);
    tag = "R8 reset mid-run";
    rst_n = 1'b0;
    run(5, 0);
    rst_n = 1'b1;
    init_done = 1'b0;
    run(10, 0);
    init_done = 1'b1;
    run(100, 0);
    tag = "R6 random mix";
    for (int s = 0; s < 15; s++) begin
      ratio_a = 8'($urandom_range(255, 0)); ratio_b = 8'($urandom_range(60, 0));
      post_div = 6'($urandom_range(7));
      if ($urandom_range(9) == 0) init_done = ~init_done;
      for (int i = 0; i < 2000; i++) begin
        if ($urandom_range(99) < 5) sel_b = ~sel_b;
        if ($urandom_range(999) == 0) init_done = ~init_done;
        tick();
      end
      init_done = 1'b1;
    end
    finish_run();
  end
endmodule